// File: doc/BRIEF.md
# Panel Sync and Data-Window Timing Generator

This block drives the timing of a 320x240 TFT panel that receives pixel data over a narrow parallel port. Each pixel takes either two or three port clock ticks. All timing is therefore counted in port clock ticks, and every horizontal quantity is scaled by the active clocks-per-pixel value.

A tick counter walks each line and a line counter walks each frame. From these two counters the block produces:
- active-low horizontal and vertical sync pulses;
- a data-enable window for the data path;
- one-tick strobes that mark the start of each line and the start of each frame.

The data-enable window opens later than the nominal first pixel, by a fixed number of ticks. This makes up for the pipeline delay of the downstream format converter, which is 3 ticks in two-tick mode and 5 ticks in three-tick mode. A mode change requested while a frame is running waits until the frame boundary.

The block only produces timing. Fetching the pixel data is done elsewhere, and that logic uses the strobes and the data-enable window to pace itself.

Top module: `lcd_sync_gen`

## Requirements
- R1: While `rst` is high or `enable` is low, the outputs are idle: `hsync_n`=1, `vsync_n`=1, `data_en`=0, `line_start`=0, `frame_start`=0.
- R2: With `enable` high, a line lasts H_TOT_PIX×C ticks, where C is the latched clocks-per-pixel value (2 or 3). `line_start` is high only on tick 0 of each line.
- R3: `hsync_n` is low on ticks 0 to H_SYNC_PIX×C−1 of every line and high on all other ticks.
- R4: On a visible line, `data_en` is high on exactly the ticks from S to S+H_ACT_PIX×C−1, where S = H_LEAD_PIX×C + D. D is DLY_TWO (3) when C=2 and DLY_THREE (5) when C=3. `data_en` never overlaps a sync pulse.
- R5: A frame holds V_VIS+V_BLANK lines (244 by default). `frame_start` is high only on tick 0 of line 0, and it is always accompanied by `line_start`.
- R6: `vsync_n` is low on ticks 0 to V_SYNC_PIX×C−1 of line 0 only.
- R7: The blanking lines are split evenly around the picture. The visible lines are V_BLANK/2 through V_BLANK/2+V_VIS−1 (2 to 241 by default), and `data_en` stays low on every other line.
- R8: `mode_sel` (1 = three ticks per pixel, 0 = two) is sampled only during reset, while `enable` is low, or on the tick edge that ends the last line of a frame. A change at any other time has no effect until the next frame. `mode3_active` shows the latched mode.
- R9: Dropping `enable` returns both counters to zero. When `enable` rises again, the first tick is tick 0 of line 0, so a new frame starts at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock; one tick per cycle |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the timing when high; clears the counters when low |
| mode_sel | input | 1 | Requested ticks per pixel: 1 = three, 0 = two |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| data_en | output | 1 | Active-data window, including the pipeline compensation |
| line_start | output | 1 | One-tick strobe on tick 0 of each line |
| frame_start | output | 1 | One-tick strobe on tick 0 of line 0 |
| mode3_active | output | 1 | Latched mode: 1 = three ticks per pixel |

## Verification
The bench runs in both modes and flips `mode_sel` in the middle of a frame. A design that latched the mode early would stretch or shrink the current line and shift the data-enable window part way through the frame.

It checks the first and last ticks of the data window in each mode. A design that dropped the pipeline offset, or applied the wrong offset for the mode, would open the window 3 or 5 ticks off, or be off by one at either edge.

It also checks the lines just inside and just outside the visible band. Getting the blanking split wrong would enable data on a blanking line.

Finally, it drops `enable` in the middle of a frame and then restores it. A design that kept its counters would resume mid-line instead of raising `frame_start` on the first tick back.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;

    localparam int TICK_W = 12;
    localparam int LINE_W = 9;

    typedef logic [TICK_W-1:0] tick_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef enum logic {
        CPP_TWO   = 1'b0,
        CPP_THREE = 1'b1
    } cpp_mode_e;

    // Per-mode horizontal marks, all in ticks; the *_end values are exclusive.
    typedef struct packed {
        tick_t last;
        tick_t hs_end;
        tick_t vs_end;
        tick_t de_start;
        tick_t de_end;
    } h_timing_t;

    typedef struct packed {
        logic hsync_n;
        logic vsync_n;
        logic de;
        logic line_start;
        logic frame_start;
    } sync_out_t;

    function automatic h_timing_t build_h(
        input cpp_mode_e m,
        input int act_pix,
        input int tot_pix,
        input int hs_pix,
        input int vs_pix,
        input int lead_pix,
        input int dly_two,
        input int dly_three
    );
        h_timing_t t;
        int c;
        int d;
        c = (m == CPP_THREE) ? 3 : 2;
        d = (m == CPP_THREE) ? dly_three : dly_two;
        t.last     = tick_t'(tot_pix * c - 1);
        t.hs_end   = tick_t'(hs_pix * c);
        t.vs_end   = tick_t'(vs_pix * c);
        t.de_start = tick_t'(lead_pix * c + d);
        t.de_end   = tick_t'(lead_pix * c + d + act_pix * c);
        return t;
    endfunction

endpackage

// File: rtl/lcd_tmg_mode.sv
module lcd_tmg_mode
    import lcd_tmg_pkg::*;
#(
    parameter int H_ACT_PIX  = 320,
    parameter int H_TOT_PIX  = 336,
    parameter int H_SYNC_PIX = 2,
    parameter int V_SYNC_PIX = 2,
    parameter int H_LEAD_PIX = 7,
    parameter int DLY_TWO    = 3,
    parameter int DLY_THREE  = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      run,
    input  logic      frame_wrap,
    input  logic      mode_sel,
    output cpp_mode_e mode_q,
    output h_timing_t tmg
);

    localparam h_timing_t TMG_TWO = build_h(CPP_TWO, H_ACT_PIX, H_TOT_PIX,
        H_SYNC_PIX, V_SYNC_PIX, H_LEAD_PIX, DLY_TWO, DLY_THREE);
    localparam h_timing_t TMG_THREE = build_h(CPP_THREE, H_ACT_PIX, H_TOT_PIX,
        H_SYNC_PIX, V_SYNC_PIX, H_LEAD_PIX, DLY_TWO, DLY_THREE);

    always_ff @(posedge clk) begin
        if (rst || !run || frame_wrap) begin
            mode_q <= cpp_mode_e'(mode_sel);
        end
    end

    assign tmg = (mode_q == CPP_THREE) ? TMG_THREE : TMG_TWO;

    // R8: the latched mode only moves at a frame boundary while running
    assert_mode_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (run && !frame_wrap) |=> $stable(mode_q));

endmodule

// File: rtl/lcd_tmg_hcount.sv
module lcd_tmg_hcount
    import lcd_tmg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  tick_t last_val,
    output tick_t cnt,
    output logic  at_last
);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == last_val) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + tick_t'(1);
        end
    end

    assign at_last = (cnt == last_val);

    // R2: the line wraps to tick 0 after its last tick
    assert_hwrap_R2: assert property (@(posedge clk) disable iff (rst)
        (run && at_last) |=> (cnt == '0));

    // R2: the tick count never passes the end of the line
    assert_hrange_R2: assert property (@(posedge clk) disable iff (rst)
        cnt <= last_val);

endmodule

// File: rtl/lcd_tmg_vcount.sv
module lcd_tmg_vcount
    import lcd_tmg_pkg::*;
#(
    parameter int V_TOTAL = 244
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  logic  adv,
    output line_t cnt,
    output logic  at_last
);

    localparam line_t LAST = line_t'(V_TOTAL - 1);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == LAST) ? '0 : cnt + line_t'(1);
        end
    end

    assign at_last = (cnt == LAST);

    // R5: the line number moves only at the end of a line
    assert_vhold_R5: assert property (@(posedge clk) disable iff (rst)
        (run && !adv) |=> $stable(cnt));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
    import lcd_tmg_pkg::*;
#(
    parameter int H_ACT_PIX  = 320,
    parameter int H_TOT_PIX  = 336,
    parameter int H_SYNC_PIX = 2,
    parameter int V_SYNC_PIX = 2,
    parameter int H_LEAD_PIX = 7,
    parameter int V_VIS      = 240,
    parameter int V_BLANK    = 4,
    parameter int DLY_TWO    = 3,
    parameter int DLY_THREE  = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic mode_sel,
    output logic hsync_n,
    output logic vsync_n,
    output logic data_en,
    output logic line_start,
    output logic frame_start,
    output logic mode3_active
);

    localparam int V_TOTAL   = V_VIS + V_BLANK;
    localparam int VIS_FIRST = V_BLANK / 2;
    localparam int VIS_END   = VIS_FIRST + V_VIS;

    logic      run;
    cpp_mode_e mode_q;
    h_timing_t tmg;
    tick_t     h_cnt;
    line_t     v_cnt;
    logic      h_last;
    logic      v_last;
    logic      frame_wrap;
    logic      vis_line;
    sync_out_t so;

    assign run        = enable && !rst;
    assign frame_wrap = h_last && v_last;

    lcd_tmg_mode #(
        .H_ACT_PIX (H_ACT_PIX),
        .H_TOT_PIX (H_TOT_PIX),
        .H_SYNC_PIX(H_SYNC_PIX),
        .V_SYNC_PIX(V_SYNC_PIX),
        .H_LEAD_PIX(H_LEAD_PIX),
        .DLY_TWO   (DLY_TWO),
        .DLY_THREE (DLY_THREE)
    ) u_mode (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .frame_wrap(frame_wrap),
        .mode_sel  (mode_sel),
        .mode_q    (mode_q),
        .tmg       (tmg)
    );

    lcd_tmg_hcount u_hcnt (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .last_val(tmg.last),
        .cnt     (h_cnt),
        .at_last (h_last)
    );

    lcd_tmg_vcount #(
        .V_TOTAL(V_TOTAL)
    ) u_vcnt (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .adv    (h_last),
        .cnt    (v_cnt),
        .at_last(v_last)
    );

    assign vis_line = (v_cnt >= line_t'(VIS_FIRST)) && (v_cnt < line_t'(VIS_END));

    always_comb begin
        so.hsync_n     = !(run && (h_cnt < tmg.hs_end));
        so.vsync_n     = !(run && (v_cnt == '0) && (h_cnt < tmg.vs_end));
        so.de          = run && vis_line && (h_cnt >= tmg.de_start) && (h_cnt < tmg.de_end);
        so.line_start  = run && (h_cnt == '0);
        so.frame_start = run && (h_cnt == '0) && (v_cnt == '0);
    end

    assign hsync_n      = so.hsync_n;
    assign vsync_n      = so.vsync_n;
    assign data_en      = so.de;
    assign line_start   = so.line_start;
    assign frame_start  = so.frame_start;
    assign mode3_active = (mode_q == CPP_THREE);

    // R4: the data window never overlaps either sync pulse
    assert_de_clear_R4: assert property (@(posedge clk) disable iff (rst)
        data_en |-> (hsync_n && vsync_n));

    // R5: a frame start is always also a line start
    assert_frame_line_R5: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R9: after enable rises, the first tick opens a frame
    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        ($rose(enable) && !$past(rst)) |-> frame_start);

endmodule

// File: tb/tb_lcd_sync_gen.sv
module tb_lcd_sync_gen;

    localparam int HA = 8;
    localparam int HT = 14;
    localparam int HS = 2;
    localparam int VS = 2;
    localparam int HL = 3;
    localparam int VV = 4;
    localparam int VB = 4;
    localparam int D2 = 3;
    localparam int D3 = 5;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
        logic ls;
        logic fs;
        logic m3;
        logic run;
        logic vis;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable = 1'b0;
    logic mode_sel = 1'b1;
    logic hsync_n, vsync_n, data_en, line_start, frame_start, mode3_active;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    bit done     = 1'b0;

    exp_t q[$];

    // Reference state, kept by the bench from the requirements
    int  mh = 0;
    int  mv = 0;
    int  mc = 3;
    logic p_rst = 1'b1;
    logic p_en = 1'b0;
    logic p_mode = 1'b1;

    always #10 clk = ~clk;

    lcd_sync_gen #(
        .H_ACT_PIX (HA),
        .H_TOT_PIX (HT),
        .H_SYNC_PIX(HS),
        .V_SYNC_PIX(VS),
        .H_LEAD_PIX(HL),
        .V_VIS     (VV),
        .V_BLANK   (VB),
        .DLY_TWO   (D2),
        .DLY_THREE (D3)
    ) dut (
        .clk         (clk),
        .rst         (rst),
        .enable      (enable),
        .mode_sel    (mode_sel),
        .hsync_n     (hsync_n),
        .vsync_n     (vsync_n),
        .data_en     (data_en),
        .line_start  (line_start),
        .frame_start (frame_start),
        .mode3_active(mode3_active)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s cycle %0d line %0d tick %0d: actual %b expected %b",
                     req, cyc, mv, mh, act, exp);
        end
    endtask

    // Driver: advance the reference one tick, apply new inputs, push expectation
    task automatic tick(input logic r, input logic e, input logic m);
        exp_t x;
        int ds;
        int de_end;
        @(posedge clk);
        #1;
        cyc++;
        if (p_rst || !p_en) begin
            mh = 0;
            mv = 0;
            mc = p_mode ? 3 : 2;
        end else if (mh == HT * mc - 1) begin
            mh = 0;
            if (mv == VV + VB - 1) begin
                mv = 0;
                mc = p_mode ? 3 : 2;
            end else begin
                mv++;
            end
        end else begin
            mh++;
        end
        rst = r;
        enable = e;
        mode_sel = m;
        p_rst = r;
        p_en = e;
        p_mode = m;
        ds     = HL * mc + ((mc == 3) ? D3 : D2);
        de_end = ds + HA * mc;
        x.run = e && !r;
        x.vis = (mv >= VB / 2) && (mv < VB / 2 + VV);
        x.hs  = !(x.run && mh < HS * mc);
        x.vs  = !(x.run && mv == 0 && mh < VS * mc);
        x.de  = x.run && x.vis && mh >= ds && mh < de_end;
        x.ls  = x.run && mh == 0;
        x.fs  = x.run && mh == 0 && mv == 0;
        x.m3  = (mc == 3);
        q.push_back(x);
    endtask

    // Monitor: compare each expectation away from the clock edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t x;
            x = q.pop_front();
            if (!x.run) begin
                chk("R1/R9 idle hsync_n", hsync_n, 1'b1);
                chk("R1/R9 idle vsync_n", vsync_n, 1'b1);
                chk("R1/R9 idle data_en", data_en, 1'b0);
                chk("R1/R9 idle strobes", line_start | frame_start, 1'b0);
            end else begin
                chk("R3 hsync_n", hsync_n, x.hs);
                chk("R6 vsync_n", vsync_n, x.vs);
                chk(x.vis ? "R4 data_en window" : "R7 data_en blank line", data_en, x.de);
                chk("R2 line_start", line_start, x.ls);
                chk("R5 frame_start", frame_start, x.fs);
            end
            chk("R8 mode3_active", mode3_active, x.m3);
        end
    end

    initial begin : watchdog
        while (!done && cyc < 100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: held in reset, enable low
        for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1);
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1);
        // three-tick mode, one full frame and part of the next
        for (int i = 0; i < 42 * 8 + 100; i++) tick(1'b0, 1'b1, 1'b1);
        // R8: request two-tick mode mid frame; must wait for the boundary
        for (int i = 0; i < 42 * 8 * 2; i++) tick(1'b0, 1'b1, 1'b0);
        // R9: drop enable mid frame, switch mode while stopped, resume
        for (int i = 0; i < 50; i++) tick(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 42 * 8 + 60; i++) tick(1'b0, 1'b1, 1'b1);
        // two-tick mode requested mid frame, then run two frames
        for (int i = 0; i < 28 * 8 * 2 + 300; i++) tick(1'b0, 1'b1, 1'b0);
        // R1: synchronous reset while running
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 1'b1);
        for (int i = 0; i < 42 * 8 + 10; i++) tick(1'b0, 1'b1, 1'b1);
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule